// File: doc/BRIEF.md
# Dual-Host Two-Level Interrupt Aggregator

This block gathers single-cycle event pulses from two video output ports and two video pipelines. It turns them into two active-high, level-sensitive interrupt lines, one for each processor host. Each host has its own complete register bank. In that bank, a group status register latches the events of one source. A group enable decides which of those latched bits feed a one-bit summary for the source. A summary enable decides which summaries drive the host's line. Either host can therefore watch and clear events without disturbing the other.

A separate raw view latches every event whatever any enable holds, and is cleared on its own. Software reaches all registers through a plain single-cycle register port. A write takes effect at the clock edge that samples it. A read returns data combinationally from the address. The event inputs carry no handshake: a pulse that is high at a clock edge is one event.

Top module: `dual_host_irq_agg`

## Requirements
- R1: After reset every status, raw and enable register reads 0, and both interrupt lines are low.
- R2: Raw status latches each event at the edge where its pulse is high, whatever the enables hold. Raw registers sit at 0x20 + group (groups: 0 = port A, 1 = port B, 2 = pipeline A, 3 = pipeline B). Writing 1 to a raw bit clears it. No raw bit rises without an event.
- R3: Each host's group status (host base 0x00 or 0x10, offset 2 + group) latches every event of its group, whatever the enables hold. Writing 1 clears a bit and writing 0 leaves it unchanged.
- R4: When an event and a clear write hit the same status bit in the same cycle, the bit ends up set.
- R5: A clear written to one host's status leaves the other host's status unchanged.
- R6: The summary status (host offset 0, read only) has bit 0 for port A, bit 1 for port B, bit 4 for pipeline A and bit 5 for pipeline B. Each bit is the OR of its group status ANDed with that host's group enable (offset 6 + group). A write to offset 0 has no effect.
- R7: A host's line is high exactly while its summary status ANDed with its summary enable (offset 1) is non-zero. It falls once the last contributing status bit is cleared.
- R8: Port groups implement bits 0 to 4 and 6 to 11: frame done, vsync, odd-field vsync, line match, sync lost, safety regions 0 to 3 at 6 to 9, security violation at 10, shadow sync at 11. Pipeline groups implement bit 0 underflow, bit 1 end of window and bit 2 safety mismatch. Unimplemented bits read 0.
- R9: Enable registers are plain read/write and read back the written value limited to the implemented bits. A summary enable keeps bits 0, 1, 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_a_evt | input | 12 | Event pulses from output port A |
| port_b_evt | input | 12 | Event pulses from output port B |
| pipe_a_evt | input | 3 | Event pulses from pipeline A |
| pipe_b_evt | input | 3 | Event pulses from pipeline B |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 6 | Register address for both reads and writes |
| reg_wdata | input | 12 | Write data |
| reg_rdata | output | 12 | Read data for reg_addr |
| irq | output | 2 | Interrupt line for each host (bit 0 = host 0) |

## Verification
Events are first pulsed on every bit of a group with all enables clear. This separates the latching done by the raw and status registers from the gating done by the enables, and shows which bit positions are implemented. A single vsync pulse is then routed through a chosen group enable and summary enable. Meanwhile a pipeline event with its group enable clear must not reach the summary, which tells the per-group masks apart from the per-host ones. Clears written to one host, written as zeros, and written in the same cycle as an event separate host isolation, the write-1 rule and the set-over-clear priority.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int GW = 12;  // group status width
  localparam int PW = 3;   // pipeline event width
  localparam int NG = 4;   // groups per host
  localparam int TW = 6;   // summary width
  localparam logic [GW-1:0] PORT_VALID = 12'hFDF;
  localparam logic [GW-1:0] PIPE_VALID = 12'h007;
  localparam logic [TW-1:0] TOP_VALID  = 6'b110011;

  function automatic logic [GW-1:0] grp_valid(input int g);
    return (g < 2) ? PORT_VALID : PIPE_VALID;
  endfunction

  function automatic int grp_top_bit(input int g);
    return (g < 2) ? g : g + 2;
  endfunction
endpackage

// File: rtl/irq_w1c_bank.sv
module irq_w1c_bank #(
  parameter int W = 12,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr_we,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  logic [W-1:0] clr_m;
  assign clr_m = clr_we ? clr : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= ((q & ~clr_m) | set) & VALID;
  end
endmodule

// File: rtl/irq_host_bank.sv
module irq_host_bank
  import irq_agg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NG*GW-1:0] evt,
  input  logic             wr,
  input  logic [3:0]       off,
  input  logic [GW-1:0]    wdata,
  output logic [GW-1:0]    rdata,
  output logic             irq,
  output logic [NG*GW-1:0] st_flat,
  output logic [TW-1:0]    top_en_o
);
  logic [GW-1:0] st [NG];
  logic [GW-1:0] en [NG];
  logic [TW-1:0] top_st;
  logic [TW-1:0] top_en;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    irq_w1c_bank #(.W(GW), .VALID(grp_valid(g))) u_st (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (evt[g*GW +: GW]),
      .clr_we (wr && off == 4'(2 + g)),
      .clr    (wdata),
      .q      (st[g])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)                       en[g] <= '0;
      else if (wr && off == 4'(6 + g))  en[g] <= wdata & grp_valid(g);
    end

    assign st_flat[g*GW +: GW] = st[g];
  end

  always_comb begin
    top_st = '0;
    for (int g = 0; g < NG; g++) top_st[grp_top_bit(g)] = |(st[g] & en[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              top_en <= '0;
    else if (wr && off == 4'd1) top_en <= wdata[TW-1:0] & TOP_VALID;
  end

  assign irq      = |(top_st & top_en);
  assign top_en_o = top_en;

  always_comb begin
    rdata = '0;
    if (off == 4'd0) rdata[TW-1:0] = top_st;
    else if (off == 4'd1) rdata[TW-1:0] = top_en;
    for (int g = 0; g < NG; g++) begin
      if (off == 4'(2 + g)) rdata = st[g];
      if (off == 4'(6 + g)) rdata = en[g];
    end
  end
endmodule

// File: rtl/dual_host_irq_agg.sv
module dual_host_irq_agg
  import irq_agg_pkg::*;
#(
  parameter int NH = 2,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GW-1:0] port_a_evt,
  input  logic [GW-1:0] port_b_evt,
  input  logic [PW-1:0] pipe_a_evt,
  input  logic [PW-1:0] pipe_b_evt,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [GW-1:0] reg_wdata,
  output logic [GW-1:0] reg_rdata,
  output logic [NH-1:0] irq
);
  localparam int HSTRIDE  = 16;
  localparam int RAW_BASE = NH * HSTRIDE;
  localparam int HSW      = AW - 4;

  logic [NG*GW-1:0]    evt_flat;
  logic [NG*GW-1:0]    raw_flat;
  logic [NH*NG*GW-1:0] st_all;
  logic [NH*TW-1:0]    ten_all;
  logic [GW-1:0]       h_rd [NH];
  logic [HSW-1:0]      hsel;
  logic                any_evt;

  assign evt_flat = {{(GW-PW){1'b0}}, pipe_b_evt, {(GW-PW){1'b0}}, pipe_a_evt,
                     port_b_evt, port_a_evt};
  assign any_evt  = |evt_flat;
  assign hsel     = reg_addr[AW-1:4];

  for (genvar h = 0; h < NH; h++) begin : g_host
    irq_host_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt_flat),
      .wr       (reg_wr && hsel == HSW'(h)),
      .off      (reg_addr[3:0]),
      .wdata    (reg_wdata),
      .rdata    (h_rd[h]),
      .irq      (irq[h]),
      .st_flat  (st_all[h*NG*GW +: NG*GW]),
      .top_en_o (ten_all[h*TW +: TW])
    );
  end

  for (genvar g = 0; g < NG; g++) begin : g_raw
    irq_w1c_bank #(.W(GW), .VALID(grp_valid(g))) u_raw (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (evt_flat[g*GW +: GW]),
      .clr_we (reg_wr && reg_addr == AW'(RAW_BASE + g)),
      .clr    (reg_wdata),
      .q      (raw_flat[g*GW +: GW])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int h = 0; h < NH; h++)
      if (hsel == HSW'(h)) reg_rdata = h_rd[h];
    for (int g = 0; g < NG; g++)
      if (reg_addr == AW'(RAW_BASE + g)) reg_rdata = raw_flat[g*GW +: GW];
  end
endmodule

// File: rtl/dual_host_irq_agg_chk.sv
module dual_host_irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int NH = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                any_evt,
  input logic [GW-1:0]       port_a_evt,
  input logic [NH-1:0]       irq,
  input logic [NG*GW-1:0]    raw_flat,
  input logic [NH*NG*GW-1:0] st_all,
  input logic [NH*TW-1:0]    ten_all
);
  // R2: a port A pulse is latched in raw status one edge later
  p_raw_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|port_a_evt) |=> ((raw_flat[GW-1:0] & $past(port_a_evt & PORT_VALID))
                       == $past(port_a_evt & PORT_VALID)));

  // R2: raw bits never rise without an event
  p_raw_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !any_evt |=> ((raw_flat & ~$past(raw_flat)) == '0));

  for (genvar h = 0; h < NH; h++) begin : g_h
    // R3: each host latches port A events regardless of enables
    p_host_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|port_a_evt) |=> ((st_all[h*NG*GW +: GW] & $past(port_a_evt & PORT_VALID))
                         == $past(port_a_evt & PORT_VALID)));

    // R7: a line with no summary enable stays low
    p_line_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ten_all[h*TW +: TW] == '0) |-> !irq[h]);

    // R6: a high line implies some latched status in that host
    p_line_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq[h] |-> (|st_all[h*NG*GW +: NG*GW]));
  end
endmodule

bind dual_host_irq_agg dual_host_irq_agg_chk #(.NH(NH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .any_evt    (any_evt),
  .port_a_evt (port_a_evt),
  .irq        (irq),
  .raw_flat   (raw_flat),
  .st_all     (st_all),
  .ten_all    (ten_all)
);

// File: tb/dual_host_irq_agg_test.sv
module dual_host_irq_agg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] port_a_evt = '0, port_b_evt = '0;
  logic [2:0]  pipe_a_evt = '0, pipe_b_evt = '0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [11:0] reg_wdata = '0;
  logic [11:0] reg_rdata;
  logic [1:0]  irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_host_irq_agg uut (
    .clk(clk), .rst_n(rst_n), .port_a_evt(port_a_evt), .port_b_evt(port_b_evt),
    .pipe_a_evt(pipe_a_evt), .pipe_b_evt(pipe_b_evt), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(string req, logic [5:0] a, logic [11:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic wr(logic [5:0] a, logic [11:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(logic [11:0] pa, logic [11:0] pb, logic [2:0] qa, logic [2:0] qb);
    port_a_evt = pa; port_b_evt = pb; pipe_a_evt = qa; pipe_b_evt = qb;
    @(negedge clk);
    port_a_evt = '0; port_b_evt = '0; pipe_a_evt = '0; pipe_b_evt = '0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 10; a++) begin
      rd("R1 host0", 6'(a), 12'h000);
      rd("R1 host1", 6'(16 + a), 12'h000);
    end
    for (int g = 0; g < 4; g++) rd("R1 raw", 6'(32 + g), 12'h000);
    check("R1 irq", {10'd0, irq}, 12'h000);
  endtask

  task automatic t_raw_no_enable;
    pulse(12'hFFF, 12'h000, 3'b101, 3'b000);
    rd("R2 raw port A", 6'h20, 12'hFDF);
    rd("R8 raw pipe A bits", 6'h22, 12'h005);
    rd("R3 host0 port A", 6'h02, 12'hFDF);
    rd("R3 host1 port A", 6'h12, 12'hFDF);
    check("R7 no enables irq low", {10'd0, irq}, 12'h000);
    wr(6'h20, 12'hFFF);
    rd("R2 raw cleared", 6'h20, 12'h000);
    rd("R2 raw clear keeps host", 6'h02, 12'hFDF);
  endtask

  task automatic t_w1c_and_isolation;
    wr(6'h02, 12'h001);
    rd("R3 w1c bit0", 6'h02, 12'hFDE);
    wr(6'h02, 12'h000);
    rd("R3 write 0 no effect", 6'h02, 12'hFDE);
    rd("R5 host1 untouched", 6'h12, 12'hFDF);
    wr(6'h02, 12'hFFF); wr(6'h12, 12'hFFF);
    wr(6'h22, 12'hFFF); wr(6'h04, 12'hFFF); wr(6'h14, 12'hFFF);
    rd("R3 host0 cleared", 6'h02, 12'h000);
  endtask

  task automatic t_summary_and_line;
    wr(6'h07, 12'h002);              // host0 port B enable vsync
    pulse(12'h000, 12'h002, 3'b000, 3'b001);
    rd("R6 summary port B only", 6'h00, 12'h002);
    check("R7 top enable clear", {10'd0, irq}, 12'h000);
    wr(6'h01, 12'h002);
    check("R7 host0 line high", {10'd0, irq}, 12'h001);
    wr(6'h09, 12'h001);              // host0 pipe B enable underflow
    rd("R6 summary bit5", 6'h00, 12'h022);
    wr(6'h00, 12'hFFF);
    rd("R6 summary write ignored", 6'h00, 12'h022);
    wr(6'h03, 12'h002);
    rd("R6 summary after clear", 6'h00, 12'h020);
    check("R7 line falls", {10'd0, irq}, 12'h000);
    rd("R5 host1 port B kept", 6'h13, 12'h002);
  endtask

  task automatic t_set_wins;
    reg_wr = 1'b1; reg_addr = 6'h02; reg_wdata = 12'h008; port_a_evt = 12'h008;
    @(negedge clk);
    reg_wr = 1'b0; port_a_evt = '0;
    rd("R4 set beats clear", 6'h02, 12'h008);
  endtask

  task automatic t_enable_rw;
    wr(6'h16, 12'hFFF);
    rd("R9 port enable", 6'h16, 12'hFDF);
    wr(6'h18, 12'hFFF);
    rd("R9 pipe enable", 6'h18, 12'h007);
    wr(6'h11, 12'hFFF);
    rd("R9 summary enable", 6'h11, 12'h033);
    rd("R9 host0 enable kept", 6'h06, 12'h000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_raw_no_enable();
    t_w1c_and_isolation();
    t_summary_and_line();
    t_set_wins();
    t_enable_rw();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule